// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side master for a two-wire MDIO bus. A host presents one request at a time on a valid/ready command port. A request carries an operation code, a PHY address, a register address and write data. The block turns the request into serial frames on MDC and MDIO. A read returns 16 bits of data together with a single-cycle completion strobe. The pad is outside the block, so MDIO appears as three signals: an output value, an output enable and a sampled input.

MDC is produced only while a frame is on the wire. Its frequency is the system clock divided by `2*HALF_DIV`. With the default divider and a 125 MHz clock, MDC runs close to 3 MHz.

Each request can drop the 32-bit all-ones preamble, which halves the length of the frame. An extended-register request becomes four back-to-back write frames in hardware, with no status reads between them:
1. Write 0x001F to the indirect control register.
2. Write the extended address to the indirect address/data register.
3. Write 0x401F to the indirect control register.
4. Write the data to the indirect address/data register.

Top module: `mdio_master`

## Requirements
- R1: Out of reset `cmd_ready_o` is 1, and `done_o`, `mdc_o` and `mdio_oe_o` are 0. Whenever `cmd_ready_o` is 1, `mdc_o` and `mdio_oe_o` are both 0.
- R2: A frame lasts 64 MDC rising edges when `cmd_no_pre_i` is 0, and 32 when it is 1. In the 64-edge case the first 32 bits are all ones.
- R3: The 32 bits after the preamble go out MSB first in this order: start `01`, opcode (`01` write, `10` read), 5-bit PHY address, 5-bit register address (`cmd_addr_i[4:0]`), turnaround, 16 data bits. On a write the master drives the turnaround as `10`.
- R4: On a read the master drives MDIO only up to the end of the register address. It releases MDIO for the turnaround and the 16 data bits. It samples those 16 bits on MDC rising edges, MSB first, and presents them on `rd_data_o`. `rd_data_o` holds its value until the next read.
- R5: `cmd_op_i = 2'b10` produces exactly four write frames, in this order:
  1. PHY register 0x0D with data 0x001F.
  2. Register 0x0E with `cmd_addr_i`.
  3. Register 0x0D with 0x401F.
  4. Register 0x0E with `cmd_wdata_i`.
  The preamble choice applies to all four frames.
- R6: `done_o` is a one-cycle pulse. It comes once per accepted request, after the last frame of that request ends.
- R7: A request is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. After acceptance, `cmd_ready_o` stays 0 until the request completes. Any `cmd_valid_i` activity while `cmd_ready_o` is 0 produces no frame.
- R8: MDIO output changes only while MDC is low. It never changes during an MDC high phase.
- R9: Inside a frame, MDC has a period of `2*HALF_DIV` system clocks.
- R10: Between the frames of an extended request, `mdio_oe_o` drops to 0. Each frame therefore starts with a fresh rise of the output enable.
- R11: `cmd_op_i = 2'b00` is a plain write and `2'b01` is a plain read. The reserved code `2'b11` behaves as a plain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Request present |
| cmd_ready_o | output | 1 | Block idle, request can be taken |
| cmd_op_i | input | 2 | 00 write, 01 read, 10 extended write, 11 write |
| cmd_no_pre_i | input | 1 | 1 = omit the preamble |
| cmd_phy_i | input | 5 | PHY address |
| cmd_addr_i | input | 16 | Register address (bits 4:0) or extended address |
| cmd_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Data returned by the last read |
| done_o | output | 1 | Request complete pulse |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO sampled input |

## Verification
The checker watches four rules on every cycle:
- the idle bus state (no MDC and no output enable while ready),
- ready staying low once a request is taken and while MDIO is driven,
- the single-cycle width of the completion strobe,
- MDIO holding steady through each MDC high phase.

Frame lengths, the bit content of each field, read capture through the released turnaround, the four-write order of an extended access and the MDC period depend on the sequence of a whole request. The bench's bus monitor and PHY model are the only way to show these.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_EXT   = 2'b10,
    OP_RSVD  = 2'b11
  } mdio_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_LOAD = 2'b01,
    S_WAIT = 2'b10
  } seq_state_e;

  localparam logic [1:0]  START_BITS = 2'b01;
  localparam logic [1:0]  OPC_WR     = 2'b01;
  localparam logic [1:0]  OPC_RD     = 2'b10;
  localparam logic [1:0]  TA_WR      = 2'b10;
  localparam logic [4:0]  IND_CTRL   = 5'h0D;
  localparam logic [4:0]  IND_DATA   = 5'h0E;
  localparam logic [1:0]  FN_ADDR    = 2'b00;
  localparam logic [1:0]  FN_DATA    = 2'b01;

  typedef struct packed {
    logic        wr;
    logic        no_pre;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } frame_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_DIV = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobes mark the clock edge at which mdc changes
  assign rise_o = run_i && wrap && !mdc_q;
  assign fall_o = run_i && wrap && mdc_q;
  assign mdc_o  = mdc_q;
endmodule

// File: rtl/mdio_frame_io.sv
module mdio_frame_io
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  frame_t      frame_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rd_data_o
);
  localparam int FRAME_W = 64;
  localparam int IW      = $clog2(FRAME_W);
  localparam int TA_HI   = 17;

  logic [FRAME_W-1:0] vec_q;
  logic [IW-1:0]      idx_q;
  logic               busy_q, wr_q, done_q;
  logic [15:0]        rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        wr_q   <= frame_i.wr;
        vec_q  <= {32'hFFFF_FFFF, START_BITS, frame_i.wr ? OPC_WR : OPC_RD,
                   frame_i.phy, frame_i.regad, TA_WR,
                   frame_i.wr ? frame_i.data : 16'h0000};
        idx_q  <= frame_i.no_pre ? IW'(31) : IW'(FRAME_W - 1);
      end else if (busy_q) begin
        if (rise_i && !wr_q && (idx_q < IW'(16)))
          rd_q <= {rd_q[14:0], mdio_i};
        if (fall_i) begin
          if (idx_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign mdio_o    = busy_q && vec_q[idx_q];
  // read: release from turnaround onward
  assign mdio_oe_o = busy_q && (wr_q || (idx_q > IW'(TA_HI)));
  assign rd_data_o = rd_q;
endmodule

// File: rtl/mdio_cmd_seq.sv
module mdio_cmd_seq
  import mdio_pkg::*;
#(
  parameter logic [4:0] EXT_DEVAD = 5'h1F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [1:0]  cmd_op_i,
  input  logic        cmd_no_pre_i,
  input  logic [4:0]  cmd_phy_i,
  input  logic [15:0] cmd_addr_i,
  input  logic [15:0] cmd_wdata_i,
  input  logic        frame_done_i,
  output logic        cmd_ready_o,
  output logic        start_o,
  output frame_t      frame_o,
  output logic        done_o
);
  localparam logic [15:0] CTRL_ADDR = {FN_ADDR, 9'h000, EXT_DEVAD};
  localparam logic [15:0] CTRL_DATA = {FN_DATA, 9'h000, EXT_DEVAD};

  seq_state_e  state_q;
  logic        ext_q, rd_q, nopre_q, done_q;
  logic [4:0]  phy_q;
  logic [15:0] addr_q, wdata_q;
  logic [1:0]  step_q;
  logic [1:0]  last_step;
  logic        accept;

  assign accept    = cmd_valid_i && (state_q == S_IDLE);
  assign last_step = ext_q ? 2'd3 : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ext_q   <= 1'b0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
      phy_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          ext_q   <= (cmd_op_i == OP_EXT);
          rd_q    <= (cmd_op_i == OP_READ);
          nopre_q <= cmd_no_pre_i;
          phy_q   <= cmd_phy_i;
          addr_q  <= cmd_addr_i;
          wdata_q <= cmd_wdata_i;
          step_q  <= '0;
          state_q <= S_LOAD;
        end
        S_LOAD: state_q <= S_WAIT;
        S_WAIT: if (frame_done_i) begin
          if (step_q == last_step) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_LOAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    frame_o.no_pre = nopre_q;
    frame_o.phy    = phy_q;
    if (ext_q) begin
      frame_o.wr    = 1'b1;
      frame_o.regad = step_q[0] ? IND_DATA : IND_CTRL;
      unique case (step_q)
        2'd0:    frame_o.data = CTRL_ADDR;
        2'd1:    frame_o.data = addr_q;
        2'd2:    frame_o.data = CTRL_DATA;
        default: frame_o.data = wdata_q;
      endcase
    end else begin
      frame_o.wr    = !rd_q;
      frame_o.regad = addr_q[4:0];
      frame_o.data  = wdata_q;
    end
  end

  assign start_o     = (state_q == S_LOAD);
  assign cmd_ready_o = (state_q == S_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         HALF_DIV  = 21,
  parameter logic [4:0] EXT_DEVAD = 5'h1F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic [1:0]  cmd_op_i,
  input  logic        cmd_no_pre_i,
  input  logic [4:0]  cmd_phy_i,
  input  logic [15:0] cmd_addr_i,
  input  logic [15:0] cmd_wdata_i,
  output logic [15:0] rd_data_o,
  output logic        done_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  frame_t frame;
  logic   start, busy, frame_done, rise, fall;

  mdio_cmd_seq #(.EXT_DEVAD(EXT_DEVAD)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_no_pre_i (cmd_no_pre_i),
    .cmd_phy_i    (cmd_phy_i),
    .cmd_addr_i   (cmd_addr_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .frame_done_i (frame_done),
    .cmd_ready_o  (cmd_ready_o),
    .start_o      (start),
    .frame_o      (frame),
    .done_o       (done_o)
  );

  mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_io u_io (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (frame),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (frame_done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!mdc_o && !mdio_oe_o));

  // R7
  drive_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> !cmd_ready_o);

  // R7
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  // R8
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .done_o      (done_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 4;
  localparam int NVEC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [1:0]  cmd_op_i = 2'b00;
  logic        cmd_no_pre_i = 1'b0;
  logic [4:0]  cmd_phy_i = '0;
  logic [15:0] cmd_addr_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic [15:0] rd_data_o;
  logic        done_o, mdc_o, mdio_o, mdio_oe_o;
  logic        phy_drv = 1'b1;
  logic        bus;

  int nchk = 0, nfail = 0, cyc = 0, last_rise = -1, mdc_period = 0;
  int n_fr = 0;
  int fr_cnt [4];
  logic [63:0] fr_bits [4];
  logic cur_rd = 1'b0, cur_nopre = 1'b0, ended = 1'b0;
  logic [15:0] rd_resp = '0;

  always #4 clk_i = ~clk_i;

  assign bus = mdio_oe_o ? mdio_o : phy_drv;

  mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op_i), .cmd_no_pre_i(cmd_no_pre_i), .cmd_phy_i(cmd_phy_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(bus)
  );

  // {op, no_pre, phy, addr, wdata-or-read-response}
  localparam logic [39:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 5'h01, 16'h0000, 16'h1234},
    {2'b00, 1'b1, 5'h1F, 16'h001F, 16'hFFFF},
    {2'b01, 1'b0, 5'h03, 16'h0002, 16'hA5C3},
    {2'b01, 1'b1, 5'h10, 16'h0011, 16'h8001},
    {2'b10, 1'b0, 5'h02, 16'h0834, 16'hBEEF},
    {2'b10, 1'b1, 5'h05, 16'h01A2, 16'h0001},
    {2'b11, 1'b1, 5'h07, 16'h0004, 16'h5A5A},
    {2'b00, 1'b1, 5'h00, 16'h001F, 16'h0000}
  };

  always @(posedge clk_i) cyc++;

  always @(posedge mdio_oe_o) begin
    if (n_fr < 4) begin
      fr_cnt[n_fr] = 0;
      fr_bits[n_fr] = '0;
    end
    n_fr++;
    phy_drv <= 1'b1;
  end

  always @(posedge mdc_o) begin
    if (last_rise >= 0) mdc_period = cyc - last_rise;
    last_rise = cyc;
    if (n_fr > 0 && n_fr <= 4) begin
      fr_cnt[n_fr-1]++;
      fr_bits[n_fr-1] = {fr_bits[n_fr-1][62:0], bus};
    end
  end

  // PHY model: drives on MDC falling edge
  always @(negedge mdc_o) begin
    int k;
    if (n_fr > 0 && n_fr <= 4) begin
      k = fr_cnt[n_fr-1] - (cur_nopre ? 0 : 32);
      if (cur_rd && k == 15) phy_drv <= 1'b0;
      else if (cur_rd && k >= 16 && k <= 31) phy_drv <= rd_resp[31-k];
      else phy_drv <= 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] body(input logic wr, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, wr ? 2'b01 : 2'b10, phy, ra, 2'b10, d};
  endfunction

  task automatic check_frame(input int i, input logic nopre, input logic wr,
                             input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    chk(fr_cnt[i] == (nopre ? 32 : 64), "R2 frame length", 64'(fr_cnt[i]), nopre ? 64'd32 : 64'd64);
    if (!nopre)
      chk(fr_bits[i][63:32] == 32'hFFFF_FFFF, "R2 preamble", 64'(fr_bits[i][63:32]), 64'hFFFF_FFFF);
    chk(fr_bits[i][31:0] == body(wr, phy, ra, d), wr ? "R3 write fields" : "R4 read fields",
        64'(fr_bits[i][31:0]), 64'(body(wr, phy, ra, d)));
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic nopre, input logic [4:0] phy,
                         input logic [15:0] addr, input logic [15:0] wd);
    int t;
    n_fr = 0;
    cur_rd = (op == 2'b01);
    cur_nopre = nopre;
    rd_resp = wd;
    @(negedge clk_i);
    t = 0;
    while (!cmd_ready_o && t < 20000) begin @(negedge clk_i); t++; end
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_no_pre_i = nopre;
    cmd_phy_i = phy; cmd_addr_i = addr; cmd_wdata_i = wd;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(!cmd_ready_o, "R7 ready low after accept", 64'(cmd_ready_o), 64'd0);
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    chk(done_o, "R6 done seen", 64'(done_o), 64'd1);
    chk(cmd_ready_o && !mdio_oe_o && !mdc_o, "R1 idle at done",
        64'({cmd_ready_o, mdio_oe_o, mdc_o}), 64'b100);
    @(negedge clk_i);
    chk(!done_o, "R6 done single cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      nchk++; nfail++;
      $display("FAIL R6 watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cmd_ready_o && !done_o && !mdc_o && !mdio_oe_o, "R1 reset state",
        64'({cmd_ready_o, done_o, mdc_o, mdio_oe_o}), 64'b1000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cmd_ready_o && !mdc_o && !mdio_oe_o, "R1 after reset",
        64'({cmd_ready_o, mdc_o, mdio_oe_o}), 64'b100);

    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op; logic np; logic [4:0] ph; logic [15:0] ad, wd;
      {op, np, ph, ad, wd} = VEC[v];
      run_cmd(op, np, ph, ad, wd);
      if (op == 2'b10) begin
        // R5 and R10: four separate enable rises, fixed order
        chk(n_fr == 4, "R5 R10 extended frame count", 64'(n_fr), 64'd4);
        check_frame(0, np, 1'b1, ph, 5'h0D, 16'h001F);
        check_frame(1, np, 1'b1, ph, 5'h0E, ad);
        check_frame(2, np, 1'b1, ph, 5'h0D, 16'h401F);
        check_frame(3, np, 1'b1, ph, 5'h0E, wd);
      end else begin
        // R11 op decode (reserved code acts as write)
        chk(n_fr == 1, "R11 single frame", 64'(n_fr), 64'd1);
        check_frame(0, np, op != 2'b01, ph, ad[4:0], wd);
        if (op == 2'b01)
          chk(rd_data_o == wd, "R4 read data", 64'(rd_data_o), 64'(wd));
      end
      if (v == 0)
        chk(mdc_period == 2 * HALF, "R9 MDC period", 64'(mdc_period), 64'(2 * HALF));
    end

    // R4: read data held across later writes
    chk(rd_data_o == 16'h8001, "R4 read data held", 64'(rd_data_o), 64'h8001);

    // R7: requests during a busy frame are ignored
    n_fr = 0; cur_rd = 1'b0; cur_nopre = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'b00; cmd_no_pre_i = 1'b1;
    cmd_phy_i = 5'h09; cmd_addr_i = 16'h0003; cmd_wdata_i = 16'hC0DE;
    @(negedge clk_i);
    cmd_op_i = 2'b01; cmd_phy_i = 5'h0A; cmd_wdata_i = 16'h1111;
    repeat (20) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    repeat (300) @(negedge clk_i);
    chk(n_fr == 1, "R7 busy request ignored", 64'(n_fr), 64'd1);
    check_frame(0, 1'b1, 1'b1, 5'h09, 5'h03, 16'hC0DE);
    chk(cmd_ready_o && !mdc_o, "R1 idle after ignore", 64'({cmd_ready_o, mdc_o}), 64'b10);

    // R9 again after the default-preamble extended run path
    run_cmd(2'b00, 1'b0, 5'h11, 16'h0005, 16'h0F0F);
    chk(mdc_period == 2 * HALF, "R9 MDC period long frame", 64'(mdc_period), 64'(2 * HALF));
    check_frame(0, 1'b0, 1'b1, 5'h11, 5'h05, 16'h0F0F);

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule